// File: doc/BRIEF.md
# Boundary-Scan Test Port with In-System Programming Control

This block is the serial test and configuration port of a reprogrammable logic device. A four-wire serial interface (test clock, mode select, serial in, serial out) drives a sixteen-state sequencer. The sequencer selects between an 8-bit instruction register and one of several data registers: a one-bit pass-through stage, a fixed identification word, a user-defined signature, a small pin-sampling register and a programming word that carries address and data.

Besides the usual test instructions, the port decodes a set of reconfiguration instructions. After programming mode has been unlocked, each return to the idle state sends one single-cycle strobe to a programming-memory port. The strobe is a program, erase, read or load request, and it goes out with the address and data that the last programming-word scan latched. Two status inputs, read-security and write-protect, are reported in every instruction capture. The same two inputs gate the strobes that they govern.

Top module: `isp_tap`

## Requirements
- R1: The sequencer changes state only on rising `tck_i`, following the standard sixteen-state graph steered by `tms_i`. An asynchronous low `rst_ni` puts it in Test-Logic-Reset, with `tdo_oe_o` and all strobes low.
- R2: From any state, five consecutive rising edges with `tms_i` high reach Test-Logic-Reset.
- R3: While the sequencer is in Test-Logic-Reset, the active instruction becomes IDCODE (8'h03). The identification register captures the 32-bit parameter `ID_CODE`, whose bit 0 is 1.
- R4: Capture-IR loads {4'b0000, `sec_i`, `prot_i`, 2'b01} into the instruction shift stage, with bit 0 shifted out first.
- R5: In a shift state, each rising edge moves the selected register one bit toward `tdo_o`, and `tdi_i` enters its top bit. Only the instruction register, or the one data register the instruction selects, sits in the path. Lengths: pass-through 1, identification 32, signature 32, pin register `BSR_W`, programming word `ADDR_W+DATA_W`.
- R6: `tdo_o` changes only on falling `tck_i`. `tdo_oe_o` is high only during Shift-IR and Shift-DR.
- R7: Update-IR and Update-DR load their holding registers on the falling edge. The active instruction, `bnd_o`, `pm_addr_o` and `pm_data_o` stay unchanged while shifting.
- R8: Opcodes: 8'h00 EXTEST, 8'h01 SAMPLE and 8'h02 INTEST select the pin register. 8'h04 selects the signature register. 8'h10 unlocks programming. 8'h11 program, 8'h12 erase and 8'h13 verify select the programming word. 8'h14 is load. 8'hFF and every other code select the pass-through stage, which captures 0.
- R9: Capture-DR loads `pins_i` into the pin register and `usercode_i` into the signature register. Under verify it loads {held address, `pm_rdata_i`}. Under program and erase the programming word keeps its contents.
- R10: Updating in the unlock opcode enables programming. Test-Logic-Reset disables it. No strobe is issued while programming is disabled.
- R11: The first cycle in Run-Test-Idle gives exactly one strobe for the active instruction: program→`pm_prog_o` and erase→`pm_erase_o`, both blocked by `prot_i`; verify→`pm_read_o`, blocked by `sec_i`; load→`pm_load_o`.
- R12: Update-DR of the programming word drives `pm_addr_o` from its upper `ADDR_W` bits and `pm_data_o` from its lower `DATA_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| tms_i | input | 1 | Mode select, sampled on rising edge |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, valid when enabled |
| tdo_oe_o | output | 1 | Serial output enable (low = high impedance) |
| sec_i | input | 1 | Read-security status |
| prot_i | input | 1 | Write-protect status |
| usercode_i | input | 32 | User signature captured by the signature instruction |
| pins_i | input | BSR_W | Pin values sampled by the pin register |
| bnd_o | output | BSR_W | Pin register holding outputs |
| pm_prog_o | output | 1 | Program strobe |
| pm_erase_o | output | 1 | Erase strobe |
| pm_read_o | output | 1 | Verify read strobe |
| pm_load_o | output | 1 | Load-configuration strobe |
| pm_addr_o | output | ADDR_W | Programming address |
| pm_data_o | output | DATA_W | Programming data |
| pm_rdata_i | input | DATA_W | Read data returned for verify |

## Verification
The bench uses the defaults: `BSR_W`, `ADDR_W` and `DATA_W` of 8, so the programming word is 16 bits and the largest register is 32. At these sizes every register can be shifted end to end, and its value is compared bit for bit. This makes it possible to check the kept-contents and verify-capture cases of the programming word, and the one-bit delay of the pass-through stage. Short registers also leave room to enter the reset sequence from several distinct states. They allow the strobe gating to be walked through each combination of unlock, protect and security.

// File: rtl/isp_tap_pkg.sv
package isp_tap_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 8;

  localparam logic [IR_W-1:0] OP_EXTEST   = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h01;
  localparam logic [IR_W-1:0] OP_INTEST   = 8'h02;
  localparam logic [IR_W-1:0] OP_IDCODE   = 8'h03;
  localparam logic [IR_W-1:0] OP_USERCODE = 8'h04;
  localparam logic [IR_W-1:0] OP_ISP_EN   = 8'h10;
  localparam logic [IR_W-1:0] OP_PROGRAM  = 8'h11;
  localparam logic [IR_W-1:0] OP_ERASE    = 8'h12;
  localparam logic [IR_W-1:0] OP_VERIFY   = 8'h13;
  localparam logic [IR_W-1:0] OP_LOAD     = 8'h14;
  localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;

  typedef enum logic [2:0] {DR_BYP, DR_ID, DR_USER, DR_BND, DR_PGM} dr_sel_e;
endpackage

// File: rtl/isp_tap_fsm.sv
module isp_tap_fsm
  import isp_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      default:   state_d = tms_i ? ST_SEL_DR : ST_RTI;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= state_d;

  assign state_o = state_q;

  // consecutive mode-high edges, saturating at five
  logic [2:0] ones_q;
  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)     ones_q <= '0;
    else if (!tms_i) ones_q <= '0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;

  AST_TLR_AFTER_FIVE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ones_q == 3'd5) |-> (state_q == ST_TLR)); // R2
  AST_IDLE_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_RTI && !tms_i) |=> (state_q == ST_RTI)); // R1
endmodule

// File: rtl/isp_tap_ir.sv
module isp_tap_ir
  import isp_tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  input  logic            sec_i,
  input  logic            prot_i,
  output logic [IR_W-1:0] ir_o,
  output logic            ir_tdo_o,
  output logic            isp_en_o
);
  logic [IR_W-1:0] sr_q, ir_q;
  logic            en_q;

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) sr_q <= '0;
    else if (state_i == ST_CAP_IR) sr_q <= {4'b0000, sec_i, prot_i, 2'b01};
    else if (state_i == ST_SH_IR)  sr_q <= {tdi_i, sr_q[IR_W-1:1]};

  // holding stage moves on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      ir_q <= OP_IDCODE;
      en_q <= 1'b0;
    end else if (state_i == ST_TLR) begin
      ir_q <= OP_IDCODE;
      en_q <= 1'b0;
    end else if (state_i == ST_UPD_IR) begin
      ir_q <= sr_q;
      if (sr_q == OP_ISP_EN) en_q <= 1'b1;
    end

  assign ir_o     = ir_q;
  assign ir_tdo_o = sr_q[0];
  assign isp_en_o = en_q;

  AST_IR_STABLE_SHIFT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_SH_IR) |=> $stable(ir_q)); // R7
  AST_IDCODE_ON_RESET: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_TLR) |=> (ir_q == OP_IDCODE && !en_q)); // R3
endmodule

// File: rtl/isp_tap_dr.sv
module isp_tap_dr
  import isp_tap_pkg::*;
#(
  parameter logic [31:0] ID_CODE = 32'h1A5C_3093,
  parameter int          BSR_W   = 8,
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 8
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  tap_state_e        state_i,
  input  logic              tdi_i,
  input  logic [IR_W-1:0]   ir_i,
  input  logic [31:0]       usercode_i,
  input  logic [BSR_W-1:0]  pins_i,
  input  logic [DATA_W-1:0] pm_rdata_i,
  output logic              dr_tdo_o,
  output logic [BSR_W-1:0]  bnd_o,
  output logic [ADDR_W-1:0] pm_addr_o,
  output logic [DATA_W-1:0] pm_data_o
);
  localparam int PGM_W = ADDR_W + DATA_W;
  localparam int MX_A  = (BSR_W > PGM_W) ? BSR_W : PGM_W;
  localparam int DR_W  = (MX_A > 32) ? MX_A : 32;

  dr_sel_e          sel;
  int               len;
  logic [DR_W-1:0]  sr_q, cap, nxt;
  logic [BSR_W-1:0] bnd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    unique case (ir_i)
      OP_EXTEST, OP_SAMPLE, OP_INTEST:     sel = DR_BND;
      OP_IDCODE:                           sel = DR_ID;
      OP_USERCODE:                         sel = DR_USER;
      OP_PROGRAM, OP_ERASE, OP_VERIFY:     sel = DR_PGM;
      default:                             sel = DR_BYP;
    endcase
    unique case (sel)
      DR_ID, DR_USER: len = 32;
      DR_BND:         len = BSR_W;
      DR_PGM:         len = PGM_W;
      default:        len = 1;
    endcase
  end

  always_comb begin
    cap = '0;
    unique case (sel)
      DR_ID:   cap[31:0] = ID_CODE;
      DR_USER: cap[31:0] = usercode_i;
      DR_BND:  cap[BSR_W-1:0] = pins_i;
      DR_PGM:  cap[PGM_W-1:0] = (ir_i == OP_VERIFY) ? {addr_q, pm_rdata_i}
                                                    : sr_q[PGM_W-1:0];
      default: cap = '0;
    endcase
  end

  // variable-length shift on one shared stage
  always_comb
    for (int i = 0; i < DR_W; i++) begin
      if (i == len - 1)    nxt[i] = tdi_i;
      else if (i < len - 1) nxt[i] = sr_q[i+1];
      else                 nxt[i] = 1'b0;
    end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) sr_q <= '0;
    else if (state_i == ST_CAP_DR) sr_q <= cap;
    else if (state_i == ST_SH_DR)  sr_q <= nxt;

  always_ff @(negedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      bnd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (state_i == ST_UPD_DR) begin
      if (sel == DR_BND) bnd_q <= sr_q[BSR_W-1:0];
      if (sel == DR_PGM) {addr_q, data_q} <= sr_q[PGM_W-1:0];
    end

  assign dr_tdo_o  = sr_q[0];
  assign bnd_o     = bnd_q;
  assign pm_addr_o = addr_q;
  assign pm_data_o = data_q;

  AST_BND_STABLE_SHIFT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_SH_DR) |=> $stable(bnd_q)); // R7
  AST_PGM_STABLE_SHIFT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_SH_DR) |=> ($stable(addr_q) && $stable(data_q))); // R7
endmodule

// File: rtl/isp_tap.sv
module isp_tap
  import isp_tap_pkg::*;
#(
  parameter logic [31:0] ID_CODE = 32'h1A5C_3093,
  parameter int          BSR_W   = 8,
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 8
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              tdo_oe_o,
  input  logic              sec_i,
  input  logic              prot_i,
  input  logic [31:0]       usercode_i,
  input  logic [BSR_W-1:0]  pins_i,
  output logic [BSR_W-1:0]  bnd_o,
  output logic              pm_prog_o,
  output logic              pm_erase_o,
  output logic              pm_read_o,
  output logic              pm_load_o,
  output logic [ADDR_W-1:0] pm_addr_o,
  output logic [DATA_W-1:0] pm_data_o,
  input  logic [DATA_W-1:0] pm_rdata_i
);
  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_tdo, dr_tdo, isp_en;
  logic            tdo_q, oe_q, fired_q, win;

  isp_tap_fsm u_fsm (.tck_i, .rst_ni, .tms_i, .state_o(state));

  isp_tap_ir u_ir (
    .tck_i, .rst_ni, .state_i(state), .tdi_i, .sec_i, .prot_i,
    .ir_o(ir), .ir_tdo_o(ir_tdo), .isp_en_o(isp_en)
  );

  isp_tap_dr #(.ID_CODE(ID_CODE), .BSR_W(BSR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dr (
    .tck_i, .rst_ni, .state_i(state), .tdi_i, .ir_i(ir), .usercode_i, .pins_i,
    .pm_rdata_i, .dr_tdo_o(dr_tdo), .bnd_o, .pm_addr_o, .pm_data_o
  );

  always_ff @(negedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= (state == ST_SH_IR) ? ir_tdo : dr_tdo;
      oe_q  <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end

  assign tdo_o    = tdo_q;
  assign tdo_oe_o = oe_q;

  // one strobe window per visit to idle
  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) fired_q <= 1'b0;
    else         fired_q <= (state == ST_RTI);

  assign win        = (state == ST_RTI) && !fired_q && isp_en;
  assign pm_prog_o  = win && (ir == OP_PROGRAM) && !prot_i;
  assign pm_erase_o = win && (ir == OP_ERASE)   && !prot_i;
  assign pm_read_o  = win && (ir == OP_VERIFY)  && !sec_i;
  assign pm_load_o  = win && (ir == OP_LOAD);

  AST_OE_SHIFT_ONLY: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o |-> (state == ST_SH_IR || state == ST_SH_DR)); // R6
  AST_STROBE_IN_IDLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (pm_prog_o || pm_erase_o || pm_read_o || pm_load_o) |-> (state == ST_RTI)); // R11
  AST_STROBE_SINGLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (pm_prog_o || pm_erase_o || pm_read_o || pm_load_o)
      |=> !(pm_prog_o || pm_erase_o || pm_read_o || pm_load_o)); // R11
  AST_ONE_STROBE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({pm_prog_o, pm_erase_o, pm_read_o, pm_load_o})); // R11
endmodule

// File: tb/isp_tap_bench.sv
module isp_tap_bench;
  localparam logic [31:0] IDV = 32'h1A5C_3093;

  logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic sec = 1'b0, prot = 1'b0;
  logic [31:0] ucode = 32'hC0DE_5A17;
  logic [7:0] pins = 8'hA6, rdata = 8'h9E;
  logic tdo, oe, prog, erase, rd, load;
  logic [7:0] bnd, addr, data;
  int checks = 0, errs = 0;
  bit done = 0;

  always #10 tck = ~tck;

  isp_tap u_isp_tap (
    .tck_i(tck), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi), .tdo_o(tdo), .tdo_oe_o(oe),
    .sec_i(sec), .prot_i(prot), .usercode_i(ucode), .pins_i(pins), .bnd_o(bnd),
    .pm_prog_o(prog), .pm_erase_o(erase), .pm_read_o(rd), .pm_load_o(load),
    .pm_addr_o(addr), .pm_data_o(data), .pm_rdata_i(rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic scan_ir(input logic [7:0] v, output logic [7:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 8; i++) begin
      cap[i] = tdo;
      tick(i == 7, v[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] v, output logic [63:0] out);
    logic [7:0] b0, a0, d0;
    b0 = bnd; a0 = addr; d0 = data; out = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      out[i] = tdo;
      tick(i == n - 1, v[i]);
    end
    chk("R7 outputs held before update", {bnd, addr, data}, {b0, a0, d0});
    tick(1, 0); tick(0, 0);
  endtask

  task automatic t_reset;
    logic [63:0] o;
    chk("R1 reset oe", oe, 0);
    chk("R1 reset strobes", {prog, erase, rd, load}, 0);
    tick(0, 0);
    scan_dr(32, 64'h0, o);
    chk("R3 idcode after reset", o, IDV);
  endtask

  task automatic t_ir_capture;
    logic [7:0] c;
    sec = 1; prot = 0;
    scan_ir(8'hFF, c);
    chk("R4 capture sec", c, 8'h09);
    sec = 0; prot = 1;
    scan_ir(8'h03, c);
    chk("R4 capture prot", c, 8'h05);
    prot = 0;
  endtask

  task automatic t_bypass;
    logic [7:0] c;
    logic [63:0] o;
    scan_ir(8'hFF, c);
    scan_dr(8, 64'hB5, o);
    chk("R8 bypass delay", o, 64'h6A);
    scan_ir(8'h77, c);
    scan_dr(8, 64'h3C, o);
    chk("R8 unknown opcode bypass", o, 64'h78);
    // falling-edge output timing
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R6 oe in shift", oe, 1);
    chk("R5 bypass first bit", tdo, 0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R6 tdo held at rising", tdo, 0);
    @(negedge tck); #1;
    chk("R6 tdo at falling", tdo, 1);
    tick(1, 0);
    chk("R6 oe off in exit", oe, 0);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic t_user_bnd;
    logic [7:0] c;
    logic [63:0] o;
    scan_ir(8'h04, c);
    scan_dr(32, 64'h0, o);
    chk("R9 usercode capture", o, ucode);
    scan_ir(8'h01, c);
    scan_dr(8, 64'h3C, o);
    chk("R9 pin capture", o, pins);
    chk("R7 pin update", bnd, 8'h3C);
    pins = 8'h5B;
    scan_ir(8'h00, c);
    scan_dr(8, 64'h81, o);
    chk("R5 pin length", o, 64'h5B);
    chk("R7 pin update 2", bnd, 8'h81);
  endtask

  task automatic t_tlr;
    logic [7:0] c;
    logic [63:0] o;
    logic [7:0] pre [3] = '{8'b001, 8'b010011, 8'b101001};
    int plen [3] = '{3, 6, 6};
    for (int k = 0; k < 3; k++) begin
      scan_ir(8'hFF, c);
      for (int j = 0; j < plen[k]; j++) tick(pre[k][j], 0);
      repeat (5) tick(1, 0);
      tick(0, 0);
      scan_dr(32, 64'h0, o);
      chk("R2 five ones reach reset, R3 idcode", o, IDV);
    end
  endtask

  task automatic t_isp;
    logic [7:0] c;
    logic [63:0] o;
    scan_ir(8'h11, c);
    scan_dr(16, 64'h5AC3, o);
    chk("R10 no strobe when locked", prog, 0);
    chk("R12 address", addr, 8'h5A);
    chk("R12 data", data, 8'hC3);
    scan_ir(8'h10, c);
    scan_ir(8'h11, c);
    chk("R11 program on idle entry", prog, 1);
    tick(0, 0);
    chk("R11 program single", prog, 0);
    scan_dr(16, 64'h1234, o);
    chk("R9 program keeps word", o, 64'h5AC3);
    chk("R11 program strobe", {prog, addr, data}, {1'b1, 8'h12, 8'h34});
    tick(0, 0);
    chk("R11 strobe ends", prog, 0);
    scan_ir(8'h12, c);
    chk("R11 erase strobe", {prog, erase, rd, load}, 4'b0100);
    prot = 1;
    scan_ir(8'h11, c);
    chk("R11 protect blocks program", prog, 0);
    scan_ir(8'h12, c);
    chk("R11 protect blocks erase", erase, 0);
    prot = 0;
    scan_ir(8'h13, c);
    chk("R11 verify read", rd, 1);
    scan_dr(16, 64'h4000, o);
    chk("R9 verify capture", o, 64'h129E);
    chk("R11 verify read addr", {rd, addr}, {1'b1, 8'h40});
    sec = 1;
    scan_ir(8'h13, c);
    chk("R11 security blocks read", rd, 0);
    sec = 0;
    scan_ir(8'h14, c);
    chk("R11 load strobe", {prog, erase, rd, load}, 4'b0001);
    repeat (5) tick(1, 0);
    tick(0, 0);
    scan_ir(8'h11, c);
    chk("R10 reset relocks", prog, 0);
  endtask

  initial begin
    repeat (2) @(negedge tck);
    #1 rst_n = 1;
    t_reset();
    t_ir_capture();
    t_bypass();
    t_user_bnd();
    t_tlr();
    t_isp();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end
endmodule